// File: doc/BRIEF.md
# Multi-Slot Serial Output Sequencer

This block turns one channel's latest I and Q samples into a framed bit stream on a one-bit serial line. A frame is built from seven time slots. Each slot has its own control byte, which picks what the slot carries (I, Q or zeros), how many bits it lasts, and whether a sync pulse goes with it. Bits leave most significant first, one per clock. Slots that are given no width take no clocks, so the next slot with a width follows directly.

A start pulse captures the samples and the slot configuration. It also restarts a 12-bit start delay, counted in clocks, that sets where this channel's frame begins. Several copies of the block, one per channel, feed a single line through an OR gate. Their delays, or slots that hold zeros, keep their data apart. A two-bit routing mask decides whether the channel drives the primary output, the secondary output, or both. Slot syncs and a frame sync exist only on the primary output. A two-bit field places each slot sync before, on the first bit of, on the last bit of, or after its slot.

Top module: `ser_slot_seq`

## Requirements
- R1: While rst_ni is low, and on the first clock period after it rises, ser_pri_o, ser_sec_o, sync_o and frame_sync_o are 0.
- R2: When the channel is idle, or the frame has no slot with a nonzero width, every output stays 0.
- R3: Slot byte fields are: bit 7 sync enable, bits 6:3 width code, bits 2:0 content (1 = I, 2 = Q, anything else = zeros). Data leaves MSB first. The samples in use are those present on the clock edge that samples start_i, so later sample changes have no effect on the frame.
- R4: Frame bit j appears on the serial outputs delay+2+j clock periods after the edge that samples start_i. The delay value is captured on that edge.
- R5: Slots are sent in order 0 to 6. A slot of width zero takes no clocks, and the next slot with a width starts on the following clock.
- R6: A slot whose content is zeros but whose width code is nonzero drives 0 for its full width and still takes its clocks.
- R7: Width code n gives 0 bits for n = 0 and 4*(n-1) bits otherwise, capped at 32. A slot shorter than 32 bits sends the top bits of its sample. Code 9 is 32 bits (byte 0xC9 = I, 32 bits, sync; byte 0x4A = Q, 32 bits, no sync).
- R8: sync_pos_i places each enabled slot's one-clock sync as follows: 0 = the clock before the slot's first bit, 1 = on its first bit, 2 = on its last bit, 3 = the clock after its last bit.
- R9: A slot sync is raised only for a slot with bit 7 set and a nonzero width, and only while route_i[0] is 1.
- R10: route_i[0] enables ser_pri_o and route_i[1] enables ser_sec_o. A disabled output stays 0. The route bits are applied with the same latency as the data.
- R11: frame_sync_o is a one-clock pulse on the clock that carries the frame's first bit, gated by route_i[0].
- R12: A start pulse during a frame abandons the rest of that frame. The new frame follows R4.
- R13: Two channels whose outputs are ORed interleave without collision when their slots or delays do not overlap (for example, delay 0 and delay 64 with 0xC9/0x4A frames give I0, Q0, I1, Q1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start; latches samples, slot bytes and delay |
| i_sample_i | input | SAMPLE_W | I sample |
| q_sample_i | input | SAMPLE_W | Q sample |
| slot_cfg_i | input | SLOTS*CFG_W | Slot control bytes, slot k in bits 8k+7:8k |
| delay_i | input | DELAY_W | Start delay in clocks |
| route_i | input | 2 | Output enables: bit 0 primary, bit 1 secondary |
| sync_pos_i | input | 2 | Slot sync placement |
| ser_pri_o | output | 1 | Primary serial data |
| ser_sec_o | output | 1 | Secondary serial data |
| sync_o | output | 1 | Slot sync, primary only |
| frame_sync_o | output | 1 | Frame start marker, primary only |

## Verification
Most internal errors appear on the serial line within two clocks. A wrong delay count shifts the whole frame, and the first data bit lands on the wrong clock. A wrong slot offset or width moves every later bit. On an ORed line that shows up as bits colliding with the other channel. A sync placed at the wrong position, or a wrong pipeline tap, shows as a pulse one to three clocks away from the slot edge it belongs to. A stale sample latch shows as the changed sample value appearing in the data bits.

// File: rtl/ser_seq_pkg.sv
package ser_seq_pkg;
  localparam int unsigned SEQ_SLOTS    = 7;
  localparam int unsigned SEQ_SAMPLE_W = 32;
  localparam int unsigned SEQ_CFG_W    = 8;
  localparam int unsigned SEQ_DELAY_W  = 12;
  localparam int unsigned SEQ_WSTEP    = 4;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WAIT = 2'd1,
    ENG_RUN  = 2'd2
  } eng_state_e;

  typedef enum logic [1:0] {
    SYNC_BEFORE = 2'd0,
    SYNC_FIRST  = 2'd1,
    SYNC_LAST   = 2'd2,
    SYNC_AFTER  = 2'd3
  } sync_pos_e;

  localparam logic [1:0] SRC_ZERO = 2'b00;
  localparam logic [1:0] SRC_I    = 2'b01;
  localparam logic [1:0] SRC_Q    = 2'b10;
endpackage

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned WSTEP    = 4,
  parameter int unsigned LEN_W    = 6
) (
  input  logic [SLOTS*CFG_W-1:0]         cfg_i,
  output logic [SLOTS-1:0][LEN_W-1:0]    len_o,
  output logic [SLOTS-1:0][1:0]          src_o,
  output logic [SLOTS-1:0]               sync_en_o
);
  import ser_seq_pkg::*;

  localparam int unsigned FW = LEN_W + 4;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [3:0]    code;
    logic [2:0]    sel;
    logic [FW-1:0] w_full;

    assign code = cfg_i[k*CFG_W+3 +: 4];
    assign sel  = cfg_i[k*CFG_W +: 3];
    assign sync_en_o[k] = cfg_i[k*CFG_W+7];

    assign w_full = (code == 4'd0) ? '0 : FW'(WSTEP) * (FW'(code) - FW'(1));
    assign len_o[k] = (w_full > FW'(SAMPLE_W)) ? LEN_W'(SAMPLE_W) : w_full[LEN_W-1:0];

    always_comb begin
      unique case (sel)
        3'd1:    src_o[k] = SRC_I;
        3'd2:    src_o[k] = SRC_Q;
        default: src_o[k] = SRC_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/slot_locate.sv
module slot_locate #(
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned POS_W    = 8
) (
  input  logic [SLOTS-1:0][LEN_W-1:0] len_i,
  input  logic [SLOTS-1:0][1:0]       src_i,
  input  logic [SLOTS-1:0]            sync_en_i,
  input  logic [SAMPLE_W-1:0]         i_smp_i,
  input  logic [SAMPLE_W-1:0]         q_smp_i,
  input  logic                        run_i,
  input  logic [POS_W-1:0]            pos_i,
  output logic [POS_W-1:0]            total_o,
  output logic                        bit_o,
  output logic                        first_sync_o,
  output logic                        last_sync_o,
  output logic                        head_o
);
  import ser_seq_pkg::*;

  localparam int unsigned IDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [SLOTS:0][POS_W-1:0] off;
  logic [SLOTS-1:0]          hit, first, last, bitk;

  assign off[0] = '0;

  for (genvar k = 0; k < SLOTS; k++) begin : g_loc
    logic [POS_W-1:0]    rel;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] smp;

    // running sum of widths gives each slot's start inside the frame
    assign off[k+1] = off[k] + POS_W'(len_i[k]);
    assign hit[k]   = run_i && (pos_i >= off[k]) && (pos_i < off[k+1]);
    assign rel      = pos_i - off[k];
    assign idx      = IDX_W'(SAMPLE_W - 1) - rel[IDX_W-1:0];
    assign smp      = (src_i[k] == SRC_I) ? i_smp_i :
                      (src_i[k] == SRC_Q) ? q_smp_i : '0;
    assign bitk[k]  = hit[k] & smp[idx];
    assign first[k] = hit[k] & (pos_i == off[k]);
    assign last[k]  = hit[k] & (pos_i == off[k+1] - POS_W'(1));
  end

  assign total_o      = off[SLOTS];
  assign bit_o        = |bitk;
  assign first_sync_o = |(first & sync_en_i);
  assign last_sync_o  = |(last & sync_en_i);
  assign head_o       = run_i && (pos_i == '0);
endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
  parameter int unsigned DELAY_W = 12,
  parameter int unsigned POS_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic [POS_W-1:0]   total_i,
  output logic               run_o,
  output logic               busy_o,
  output logic [POS_W-1:0]   pos_o
);
  import ser_seq_pkg::*;

  eng_state_e         state_q;
  logic [DELAY_W-1:0] cnt_q;
  logic [POS_W-1:0]   pos_q;
  logic               at_end;

  assign at_end = ((POS_W+1)'(pos_q) + (POS_W+1)'(1)) >= (POS_W+1)'(total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      pos_q   <= '0;
    end else if (start_i) begin
      cnt_q   <= delay_i;
      pos_q   <= '0;
      state_q <= (delay_i == '0) ? ENG_RUN : ENG_WAIT;
    end else begin
      unique case (state_q)
        ENG_WAIT: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == DELAY_W'(1)) state_q <= ENG_RUN;
        end
        ENG_RUN: begin
          if (at_end) begin
            state_q <= ENG_IDLE;
            pos_q   <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o  = (state_q == ENG_RUN) && (pos_q < total_i);
  assign busy_o = (state_q != ENG_IDLE);
  assign pos_o  = pos_q;
endmodule

// File: rtl/ser_out_stage.sv
module ser_out_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       first_sync_i,
  input  logic       last_sync_i,
  input  logic       head_i,
  input  logic [1:0] route_i,
  input  logic [1:0] sync_pos_i,
  output logic       ser_pri_o,
  output logic       ser_sec_o,
  output logic       sync_o,
  output logic       frame_sync_o
);
  import ser_seq_pkg::*;

  logic d1_bit, d1_first, d1_last, d1_head, d2_last;
  logic sync_sel;

  // data leaves two clocks after the engine; taps around that give the sync positions
  always_comb begin
    unique case (sync_pos_e'(sync_pos_i))
      SYNC_BEFORE: sync_sel = first_sync_i;
      SYNC_FIRST:  sync_sel = d1_first;
      SYNC_LAST:   sync_sel = d1_last;
      default:     sync_sel = d2_last;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_bit       <= 1'b0;
      d1_first     <= 1'b0;
      d1_last      <= 1'b0;
      d1_head      <= 1'b0;
      d2_last      <= 1'b0;
      ser_pri_o    <= 1'b0;
      ser_sec_o    <= 1'b0;
      sync_o       <= 1'b0;
      frame_sync_o <= 1'b0;
    end else begin
      d1_bit       <= bit_i;
      d1_first     <= first_sync_i;
      d1_last      <= last_sync_i;
      d1_head      <= head_i;
      d2_last      <= d1_last;
      ser_pri_o    <= d1_bit & route_i[0];
      ser_sec_o    <= d1_bit & route_i[1];
      sync_o       <= sync_sel & route_i[0];
      frame_sync_o <= d1_head & route_i[0];
    end
  end
endmodule

// File: rtl/ser_slot_seq.sv
module ser_slot_seq
  import ser_seq_pkg::*;
#(
  parameter int unsigned SLOTS    = SEQ_SLOTS,
  parameter int unsigned SAMPLE_W = SEQ_SAMPLE_W,
  parameter int unsigned CFG_W    = SEQ_CFG_W,
  parameter int unsigned DELAY_W  = SEQ_DELAY_W,
  parameter int unsigned WSTEP    = SEQ_WSTEP
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [SAMPLE_W-1:0]      i_sample_i,
  input  logic [SAMPLE_W-1:0]      q_sample_i,
  input  logic [SLOTS*CFG_W-1:0]   slot_cfg_i,
  input  logic [DELAY_W-1:0]       delay_i,
  input  logic [1:0]               route_i,
  input  logic [1:0]               sync_pos_i,
  output logic                     ser_pri_o,
  output logic                     ser_sec_o,
  output logic                     sync_o,
  output logic                     frame_sync_o
);
  localparam int unsigned LEN_W = $clog2(SAMPLE_W + 1);
  localparam int unsigned POS_W = $clog2(SLOTS * SAMPLE_W + 1);

  logic [SAMPLE_W-1:0]       i_q, q_q;
  logic [SLOTS*CFG_W-1:0]    cfg_q;
  logic [SLOTS-1:0][LEN_W-1:0] len;
  logic [SLOTS-1:0][1:0]     src;
  logic [SLOTS-1:0]          sync_en;
  logic [POS_W-1:0]          total, pos;
  logic                      run, eng_busy;
  logic                      bit_w, first_sync, last_sync, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q   <= '0;
      q_q   <= '0;
      cfg_q <= '0;
    end else if (start_i) begin
      i_q   <= i_sample_i;
      q_q   <= q_sample_i;
      cfg_q <= slot_cfg_i;
    end
  end

  slot_decode #(
    .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .CFG_W(CFG_W), .WSTEP(WSTEP), .LEN_W(LEN_W)
  ) u_decode (
    .cfg_i     (cfg_q),
    .len_o     (len),
    .src_o     (src),
    .sync_en_o (sync_en)
  );

  seq_engine #(.DELAY_W(DELAY_W), .POS_W(POS_W)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .delay_i (delay_i),
    .total_i (total),
    .run_o   (run),
    .busy_o  (eng_busy),
    .pos_o   (pos)
  );

  slot_locate #(
    .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .POS_W(POS_W)
  ) u_locate (
    .len_i        (len),
    .src_i        (src),
    .sync_en_i    (sync_en),
    .i_smp_i      (i_q),
    .q_smp_i      (q_q),
    .run_i        (run),
    .pos_i        (pos),
    .total_o      (total),
    .bit_o        (bit_w),
    .first_sync_o (first_sync),
    .last_sync_o  (last_sync),
    .head_o       (head)
  );

  ser_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_w),
    .first_sync_i (first_sync),
    .last_sync_i  (last_sync),
    .head_i       (head),
    .route_i      (route_i),
    .sync_pos_i   (sync_pos_i),
    .ser_pri_o    (ser_pri_o),
    .ser_sec_o    (ser_sec_o),
    .sync_o       (sync_o),
    .frame_sync_o (frame_sync_o)
  );
endmodule

// File: rtl/ser_slot_seq_chk.sv
module ser_slot_seq_chk #(
  parameter int unsigned DELAY_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [DELAY_W-1:0] delay_i,
  input logic [1:0]         route_i,
  input logic               ser_pri_o,
  input logic               ser_sec_o,
  input logic               sync_o,
  input logic               frame_sync_o,
  input logic               busy_i
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_i, 2) |-> (!ser_pri_o && !ser_sec_o && !frame_sync_o));

  // R4
  delay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && delay_i != '0) |-> ##3 (!ser_pri_o && !ser_sec_o && !frame_sync_o));

  // R9
  sync_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(route_i[0]));

  // R10
  sec_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sec_o |-> $past(route_i[1]));

  // R11
  fsync_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> $past(route_i[0]));
endmodule

bind ser_slot_seq ser_slot_seq_chk #(.DELAY_W(DELAY_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .delay_i      (delay_i),
  .route_i      (route_i),
  .ser_pri_o    (ser_pri_o),
  .ser_sec_o    (ser_sec_o),
  .sync_o       (sync_o),
  .frame_sync_o (frame_sync_o),
  .busy_i       (eng_busy)
);

// File: tb/ser_slot_seq_tb_top.sv
`timescale 1ns/1ps
module ser_slot_seq_tb_top;
  localparam int NCYC = 8192;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        start_a = 0, start_b = 0;
  logic [31:0] i_a = 0, q_a = 0, i_b = 0, q_b = 0;
  logic [55:0] cfg_a = 0, cfg_b = 0;
  logic [11:0] dly_a = 0, dly_b = 0;
  logic [1:0]  route_a = 2'b01, route_b = 2'b01;
  logic [1:0]  spos = 2'd1;
  logic [1:0]  pri, sec, syn, fs;

  ser_slot_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_a),
    .i_sample_i(i_a), .q_sample_i(q_a), .slot_cfg_i(cfg_a), .delay_i(dly_a),
    .route_i(route_a), .sync_pos_i(spos),
    .ser_pri_o(pri[0]), .ser_sec_o(sec[0]), .sync_o(syn[0]), .frame_sync_o(fs[0]));

  ser_slot_seq dut_b_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b),
    .i_sample_i(i_b), .q_sample_i(q_b), .slot_cfg_i(cfg_b), .delay_i(dly_b),
    .route_i(route_b), .sync_pos_i(spos),
    .ser_pri_o(pri[1]), .ser_sec_o(sec[1]), .sync_o(syn[1]), .frame_sync_o(fs[1]));

  // reference timeline, indexed by clock period after the edge that starts it
  bit       ev_bit [2][NCYC];
  bit       ev_fsy [2][NCYC];
  bit       ev_lsy [2][NCYC];
  bit       ev_hd  [2][NCYC];
  bit [1:0] rt_e   [2][NCYC];
  bit [1:0] ps_e   [NCYC];

  int    cyc = 0;
  int    nchk = 0, nfail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc < NCYC) begin
      rt_e[0][cyc] = route_a;
      rt_e[1][cyc] = route_b;
      ps_e[cyc]    = spos;
    end
  end

  function automatic int slot_len(logic [7:0] b);
    int n;
    n = int'(b[6:3]);
    if (n == 0) return 0;
    n = 4 * (n - 1);
    return (n > 32) ? 32 : n;
  endfunction

  task automatic schedule(int ch, int c, logic [55:0] cfg, int d, logic [31:0] iv, logic [31:0] qv);
    int f;
    for (int m = c; m < NCYC; m++) begin
      ev_bit[ch][m] = 0; ev_fsy[ch][m] = 0; ev_lsy[ch][m] = 0; ev_hd[ch][m] = 0;
    end
    f = 0;
    for (int s = 0; s < 7; s++) begin
      logic [7:0] b;
      int w;
      b = cfg[s*8 +: 8];
      w = slot_len(b);
      for (int k = 0; k < w; k++) begin
        int m;
        m = c + d + f;
        if (m < NCYC) begin
          ev_bit[ch][m] = (b[2:0] == 3'd1) ? iv[31-k] : (b[2:0] == 3'd2) ? qv[31-k] : 1'b0;
          ev_fsy[ch][m] = b[7] && (k == 0);
          ev_lsy[ch][m] = b[7] && (k == w - 1);
          ev_hd[ch][m]  = (f == 0);
        end
        f++;
      end
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s cycle %0d actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit exp_data(int ch, int k);
    return (k >= 2) && ev_bit[ch][k-2];
  endfunction

  function automatic bit exp_sync(int ch, int k);
    bit s;
    case (ps_e[k])
      2'd0:    s = (k >= 1) && ev_fsy[ch][k-1];
      2'd1:    s = (k >= 2) && ev_fsy[ch][k-2];
      2'd2:    s = (k >= 2) && ev_lsy[ch][k-2];
      default: s = (k >= 3) && ev_lsy[ch][k-3];
    endcase
    return s && rt_e[ch][k][0];
  endfunction

  always @(negedge clk) begin
    int k;
    bit line_exp;
    k = cyc;
    if (k < NCYC && !done) begin
      line_exp = 0;
      for (int ch = 0; ch < 2; ch++) begin
        bit d;
        d = exp_data(ch, k);
        chk(cur_req, "ser_pri", pri[ch], d && rt_e[ch][k][0]);
        chk(cur_req, "ser_sec", sec[ch], d && rt_e[ch][k][1]);
        chk(cur_req, "sync",    syn[ch], exp_sync(ch, k));
        chk(cur_req, "fsync",   fs[ch],  (k >= 2) && ev_hd[ch][k-2] && rt_e[ch][k][0]);
        line_exp = line_exp | (d && rt_e[ch][k][0]);
      end
      // R13: shared line is the OR of both channels
      chk("R13", "or_line", pri[0] | pri[1], line_exp);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic fire(bit do_a, bit do_b);
    if (do_a) begin
      start_a = 1;
      schedule(0, cyc + 1, cfg_a, int'(dly_a), i_a, q_a);
    end
    if (do_b) begin
      start_b = 1;
      schedule(1, cyc + 1, cfg_b, int'(dly_b), i_b, q_b);
    end
    step(1);
    start_a = 0;
    start_b = 0;
    // samples move on after the start; the frame must keep the captured ones
    i_a = ~i_a ^ 32'h1357_9BDF;
    q_a = ~q_a ^ 32'h2468_ACE0;
    i_b = ~i_b;
    q_b = ~q_b;
  endtask

  initial begin
    #56000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    step(5);
    rst_ni = 1;
    step(3);

    cur_req = "R3";
    cfg_a = {40'h0, 8'h4A, 8'hC9};
    dly_a = 0;
    i_a = 32'hA5C3_0F17;
    q_a = 32'h3C96_E1B8;
    fire(1, 0);
    step(75);

    cur_req = "R13";
    cfg_a = {40'h0, 8'h4A, 8'hC9};
    cfg_b = {40'h0, 8'h4A, 8'hC9};
    dly_a = 0;
    dly_b = 64;
    i_b = 32'hF00D_1234;
    q_b = 32'h8001_7FFE;
    fire(1, 1);
    step(140);

    cur_req = "R4";
    dly_a = 5;
    fire(1, 0);
    step(80);

    cur_req = "R5";
    cfg_a = {8'h22, 8'h61, 8'h28, 8'h1A, 8'h09, 8'h11, 8'h00};
    dly_a = 3;
    fire(1, 0);
    step(90);

    cur_req = "R6";
    cfg_a = {40'h0, 8'hC9, 8'h48};
    dly_a = 0;
    fire(1, 0);
    step(75);

    cur_req = "R7";
    cfg_a = {40'h0, 8'h21, 8'h61};
    dly_a = 1;
    fire(1, 0);
    step(55);

    cur_req = "R8";
    for (int p = 0; p < 4; p++) begin
      spos = 2'(p);
      step(1);
      cfg_a = {40'h0, 8'hCA, 8'h91};
      dly_a = (p == 0) ? 12'd0 : 12'd2;
      fire(1, 0);
      step(45);
    end
    spos = 2'd1;

    cur_req = "R9";
    cfg_a = {32'h0, 8'h11, 8'h89, 8'h80, 8'h00};
    dly_a = 0;
    fire(1, 0);
    step(15);
    route_a = 2'b10;
    cfg_a = {40'h0, 8'hCA, 8'h91};
    fire(1, 0);
    step(45);

    cur_req = "R10";
    route_a = 2'b11;
    cfg_a = {40'h0, 8'h4A, 8'hC9};
    fire(1, 0);
    step(70);
    route_a = 2'b00;
    fire(1, 0);
    step(70);
    route_a = 2'b01;
    step(2);

    cur_req = "R11";
    i_a = 32'h0123_4567;
    cfg_a = {40'h0, 8'hC9, 8'h00};
    dly_a = 7;
    fire(1, 0);
    step(45);

    cur_req = "R2";
    cfg_a = '0;
    dly_a = 0;
    fire(1, 0);
    step(20);

    cur_req = "R12";
    cfg_a = {40'h0, 8'h4A, 8'hC9};
    dly_a = 2;
    fire(1, 0);
    step(20);
    fire(1, 0);
    step(80);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule